// File: doc/BRIEF.md
# Decimation Rate Conversion Timer

This block sets the pace at which a sigma-delta converter produces finished results. A modulator tick is taken from the input clock, either on every cycle or on every second cycle. The modulator ticks are then grouped into output words. A result becomes due once a full decimation window has passed, which is `OSR_MULT` ticks for each unit of the decimation rate. A three-bit selector picks the decimation rate from a fixed set of eight irregular values.

While the hold input is low, the timer runs on its own. At the end of every window it emits a one-cycle strobe that tells the data path to latch a new result, and it drives an active-low data-ready flag low. That flag goes back high one cycle before the next strobe, so a host polling it never takes a stale word for a fresh one. Raising hold stops the cadence and clears it. When hold is released, a whole new window starts.

The filter arithmetic and the result register belong to the surrounding data path and are not part of this block.

Top module: `decim_rate_timer`

## Requirements
- R1: While `rst` is high, `result_stb` is 0 and `data_ready_n` is 1. Both return to these values one cycle after `rst` is raised, even in the middle of a period.
- R2: In steady state the number of input clocks between two strobes is `OSR_MULT` × rate × k. Here k = 1 when `mod_full_speed` = 1 and k = 2 when it is 0. The rate is looked up from `rate_sel` (bit 2 is the clock-range bit, bits 1:0 are the filter bits): 0→391, 1→313, 2→78, 3→39, 4→384, 5→320, 6→77, 7→38.
- R3: While `conv_hold` stays low, strobes keep coming with no further input.
- R4: `result_stb` is high for exactly one cycle per result.
- R5: `data_ready_n` falls in the same cycle that `result_stb` is high, and it stays low during the cycle that follows.
- R6: In the cycle just before each strobe, `data_ready_n` is high.
- R7: While `conv_hold` is high, no strobe is produced. From the next cycle on, `data_ready_n` is high.
- R8: With `mod_full_speed` = 1, when `conv_hold` falls, the first strobe is seen `OSR_MULT` × rate + 1 cycles later.
- R9: A change of `rate_sel` during a period does not affect that period. It takes effect from the next period onward.
- R10: `mod_tick` is high on every cycle when `mod_full_speed` = 1 and on every other cycle when it is 0. It keeps running while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_hold | input | 1 | High: stop and clear the cadence; low: run freely |
| rate_sel | input | 3 | Decimation-rate selector {range bit, filter bit 1, filter bit 0} |
| mod_full_speed | input | 1 | 1: modulator ticks every clock; 0: every second clock |
| result_stb | output | 1 | One-cycle pulse: latch a new result |
| data_ready_n | output | 1 | Active-low data-ready flag |
| mod_tick | output | 1 | Modulator clock enable, running even in reset |

## Verification
The assertions check the following on every cycle: the strobe is a single-cycle pulse, a held cadence makes no strobe and keeps the flag high, the flag falls only together with a strobe and is high just before one, the counters stay inside the current window, the latched rate changes only at a boundary, and the tick alternates at half speed. Some behaviour can only be shown by the bench scenarios. These are the exact period for each of the sixteen selector and speed combinations, the delay from releasing hold to the first strobe, a selector change taking effect only at the next boundary, and the tick running through reset.

// File: rtl/decim_timer_pkg.sv
package decim_timer_pkg;

  localparam int SEL_W  = 3;
  localparam int RATE_W = 9;

  typedef logic [SEL_W-1:0]  rate_sel_t;
  typedef logic [RATE_W-1:0] rate_t;

  // Decimation rate per selector code; bit 2 picks the clock range.
  function automatic rate_t rate_lookup(input rate_sel_t sel);
    rate_t r;
    case (sel)
      3'd0:    r = 9'd391;
      3'd1:    r = 9'd313;
      3'd2:    r = 9'd78;
      3'd3:    r = 9'd39;
      3'd4:    r = 9'd384;
      3'd5:    r = 9'd320;
      3'd6:    r = 9'd77;
      default: r = 9'd38;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dt_mod_prescaler.sv
module dt_mod_prescaler (
  input  logic clk,
  input  logic rst,
  input  logic full_speed,
  output logic tick
);
  // Free-running phase flop: deliberately not reset so the modulator
  // clock enable keeps running while the rest of the block is held.
  logic phase_q = 1'b0;

  always_ff @(posedge clk) begin
    phase_q <= ~phase_q;
  end

  assign tick = full_speed | phase_q;

  // R10: at half speed a tick is always followed by a gap
  assert_tick_alternates_R10: assert property (@(posedge clk) disable iff (rst)
    (!full_speed && tick) |=> (full_speed || !tick));

endmodule

// File: rtl/dt_rate_select.sv
module dt_rate_select
  import decim_timer_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load_en,
  input  rate_sel_t sel,
  output rate_t     rate_q
);
  always_ff @(posedge clk) begin
    if (rst || load_en) rate_q <= rate_lookup(sel);
  end

  // R9: the rate in use only changes at a boundary, hold or reset
  assert_rate_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> $stable(rate_q));

endmodule

// File: rtl/dt_period_counter.sv
module dt_period_counter
  import decim_timer_pkg::*;
#(
  parameter int OSR_MULT = 128,
  localparam int OS_W = (OSR_MULT > 1) ? $clog2(OSR_MULT) : 1
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  hold,
  input  logic  tick,
  input  rate_t rate,
  output logic  boundary
);
  logic [OS_W-1:0]   os_cnt;
  logic [RATE_W-1:0] dec_cnt;
  logic              os_last, dec_last;

  assign os_last  = (os_cnt == OS_W'(OSR_MULT - 1));
  assign dec_last = (dec_cnt == rate - RATE_W'(1));
  assign boundary = tick & os_last & dec_last & ~hold;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      os_cnt  <= '0;
      dec_cnt <= '0;
    end else if (tick) begin
      if (os_last) begin
        os_cnt <= '0;
        if (dec_last) dec_cnt <= '0;
        else          dec_cnt <= dec_cnt + RATE_W'(1);
      end else begin
        os_cnt <= os_cnt + OS_W'(1);
      end
    end
  end

  // R2: both counter stages stay inside the current window
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
    (32'(os_cnt) < OSR_MULT) && (dec_cnt < rate));

endmodule

// File: rtl/dt_output_stage.sv
module dt_output_stage (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic boundary,
  output logic result_stb,
  output logic data_ready_n
);
  logic warn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q       <= 1'b0;
      result_stb   <= 1'b0;
      data_ready_n <= 1'b1;
    end else begin
      warn_q     <= boundary;
      result_stb <= warn_q & ~hold;
      if (hold)          data_ready_n <= 1'b1;
      else if (warn_q)   data_ready_n <= 1'b0;
      else if (boundary) data_ready_n <= 1'b1;
    end
  end

  // R4: strobe lasts exactly one cycle
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    result_stb |=> !result_stb);

  // R7: a held cadence gives no strobe and a high flag
  assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!result_stb && data_ready_n));

endmodule

// File: rtl/decim_rate_timer.sv
module decim_rate_timer
  import decim_timer_pkg::*;
#(
  parameter int OSR_MULT = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             conv_hold,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             mod_full_speed,
  output logic             result_stb,
  output logic             data_ready_n,
  output logic             mod_tick
);
  rate_t rate_q;
  logic  boundary;

  dt_mod_prescaler u_prescaler (
    .clk        (clk),
    .rst        (rst),
    .full_speed (mod_full_speed),
    .tick       (mod_tick)
  );

  dt_rate_select u_rate (
    .clk     (clk),
    .rst     (rst),
    .load_en (conv_hold | boundary),
    .sel     (rate_sel),
    .rate_q  (rate_q)
  );

  dt_period_counter #(.OSR_MULT(OSR_MULT)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .hold     (conv_hold),
    .tick     (mod_tick),
    .rate     (rate_q),
    .boundary (boundary)
  );

  dt_output_stage u_out (
    .clk          (clk),
    .rst          (rst),
    .hold         (conv_hold),
    .boundary     (boundary),
    .result_stb   (result_stb),
    .data_ready_n (data_ready_n)
  );

  // R5: the flag only falls together with a strobe
  assert_drdy_fall_with_stb_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(data_ready_n) |-> result_stb);

  // R6: the flag was high in the cycle before every strobe
  assert_drdy_high_before_stb_R6: assert property (@(posedge clk) disable iff (rst)
    result_stb |-> $past(data_ready_n));

endmodule

// File: tb/test_decim_rate_timer.sv
module test_decim_rate_timer;
  localparam int OSR_T = 4;
  localparam int NV    = 16;

  typedef struct packed {
    logic [2:0]  sel;
    logic        full;
    logic [31:0] per;
  } vec_t;

  // R2 period = OSR_T * rate * (full ? 1 : 2)
  localparam vec_t VEC [NV] = '{
    '{3'd0, 1'b1, 32'd1564}, '{3'd1, 1'b1, 32'd1252},
    '{3'd2, 1'b1, 32'd312},  '{3'd3, 1'b1, 32'd156},
    '{3'd4, 1'b1, 32'd1536}, '{3'd5, 1'b1, 32'd1280},
    '{3'd6, 1'b1, 32'd308},  '{3'd7, 1'b1, 32'd152},
    '{3'd0, 1'b0, 32'd3128}, '{3'd1, 1'b0, 32'd2504},
    '{3'd2, 1'b0, 32'd624},  '{3'd3, 1'b0, 32'd312},
    '{3'd4, 1'b0, 32'd3072}, '{3'd5, 1'b0, 32'd2560},
    '{3'd6, 1'b0, 32'd616},  '{3'd7, 1'b0, 32'd304}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic       hold = 1'b1, full = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       stb, drdy_n, tick;
  logic       hold2 = 1'b1, full2 = 1'b1;
  logic       stb2, drdy2_n, tick2;

  int n_run  = 0;
  int n_fail = 0;

  decim_rate_timer #(.OSR_MULT(OSR_T)) i_decim_rate_timer (
    .clk(clk), .rst(rst), .conv_hold(hold), .rate_sel(sel),
    .mod_full_speed(full), .result_stb(stb), .data_ready_n(drdy_n),
    .mod_tick(tick));

  decim_rate_timer i_decim_rate_timer_full (
    .clk(clk), .rst(rst), .conv_hold(hold2), .rate_sel(3'd7),
    .mod_full_speed(full2), .result_stb(stb2), .data_ready_n(drdy2_n),
    .mod_tick(tick2));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts negedges until a strobe is seen; notes flag and width details.
  task automatic meas(input bit second, output int cyc, output bit pre_hi,
                      output bit at_lo, output bit width_ok, output bit after_lo);
    bit prev;
    cyc = 0; prev = 1'b0; width_ok = 1'b1; after_lo = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) begin
        width_ok = second ? !stb2 : !stb;
        after_lo = second ? !drdy2_n : !drdy_n;
      end
      if ((second ? stb2 : stb) || cyc > 25000) break;
      prev = second ? drdy2_n : drdy_n;
    end
    pre_hi = prev;
    at_lo  = second ? !drdy2_n : !drdy_n;
  endtask

  initial begin
    int c, cnt;
    bit p, l, w, a;

    // R10 and R1: reset state, tick keeps running in reset
    full = 1'b0; cnt = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick) cnt++;
      if (i == 19) begin
        chk(stb == 1'b0, "R1 strobe in reset", int'(stb), 0);
        chk(drdy_n == 1'b1, "R1 flag in reset", int'(drdy_n), 1);
      end
    end
    chk(cnt == 10, "R10 half-speed ticks in reset", cnt, 10);
    full = 1'b1; cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (tick) cnt++;
    end
    chk(cnt == 8, "R10 full-speed ticks in reset", cnt, 8);
    rst = 1'b0;

    // R2 R4 R5 R6: table walk over all selectors and both speeds
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      hold = 1'b1; sel = VEC[v].sel; full = VEC[v].full;
      repeat (3) @(negedge clk);
      hold = 1'b0;
      meas(1'b0, c, p, l, w, a);
      meas(1'b0, c, p, l, w, a);
      chk(c == int'(VEC[v].per), $sformatf("R2 period vec %0d", v), c, int'(VEC[v].per));
      chk(w, "R4 strobe width", int'(w), 1);
      chk(l && a, "R5 flag low with and after strobe", int'(l && a), 1);
      chk(p, "R6 flag high before strobe", int'(p), 1);
    end
    // R3: free run continues with no input change
    meas(1'b0, c, p, l, w, a);
    chk(c == 304, "R3 free-run repeat", c, 304);

    // R8: fresh start after hold release at full speed
    @(negedge clk); hold = 1'b1; full = 1'b1; sel = 3'd7;
    repeat (4) @(negedge clk);
    hold = 1'b0;
    meas(1'b0, c, p, l, w, a);
    chk(c == 153, "R8 first strobe after release", c, 153);

    // R9: selector change mid-period applies at next boundary
    sel = 3'd0;
    meas(1'b0, c, p, l, w, a);
    chk(c == 152, "R9 current period unchanged", c, 152);
    meas(1'b0, c, p, l, w, a);
    chk(c == 1564, "R9 new rate next period", c, 1564);

    // R7: hold stops strobes and raises the flag
    hold = 1'b1; cnt = 0; w = 1'b1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (stb) cnt++;
      if (!drdy_n) w = 1'b0;
    end
    chk(cnt == 0, "R7 no strobe while held", cnt, 0);
    chk(w, "R7 flag high while held", int'(w), 1);

    // R1: reset during a running period
    hold = 1'b0; sel = 3'd7;
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(stb == 1'b0 && drdy_n == 1'b1, "R1 reset mid-run", int'({stb, drdy_n}), 1);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (stb) cnt++;
    end
    chk(cnt == 0, "R1 no strobe in reset", cnt, 0);
    rst = 1'b0;

    // R2 at the default window size, both speeds
    @(negedge clk); hold2 = 1'b0; full2 = 1'b1;
    meas(1'b1, c, p, l, w, a);
    meas(1'b1, c, p, l, w, a);
    chk(c == 4864, "R2 default window full speed", c, 4864);
    hold2 = 1'b1; full2 = 1'b0;
    repeat (3) @(negedge clk);
    hold2 = 1'b0;
    meas(1'b1, c, p, l, w, a);
    meas(1'b1, c, p, l, w, a);
    chk(c == 9728, "R2 default window half speed", c, 9728);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=180000 expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule